// File: doc/BRIEF.md
# Supply-Guarded Byte Bus Front End

This block is a clocked front end for an asynchronous, byte-wide bus of the static-RAM kind. The bus has three active-low controls: chip select, output enable and write enable. The block brings these controls into the system clock domain. From them it works out read and write cycles, and it sends each access either to a bank of fourteen control registers or to a user memory region. The address decides which one.

A write window is the interval in which chip select and write enable are both low. The window therefore opens on whichever of the two falls last and closes on whichever rises first. When the window closes, the block emits one write strobe carrying the address and data present at that moment. A read drives the data bus while chip select and output enable are low and write enable is high. If write enable falls during a read, the data drivers turn off.

A supply-good input gates all access. While the supply is bad, every write and read is refused. After the supply returns, access stays locked until the supply has been good without a break for a programmable hold-off time. The hold-off is counted in system clocks. A write that has started is dropped if protection engages at any point inside its window.

Top module: `pfwp_bus_if`

## Requirements
- R1: After reset, `data_oe`, `reg_we` and `mem_we` are low and `rdata` is zero.
- R2: Addresses 0 to 13 select the register bank, so a write strobes `reg_we`. Addresses 14 and above select user memory, so a write strobes `mem_we`. A read returns `reg_rdata` for the register range and `mem_rdata` for the memory range.
- R3: Each write window produces exactly one strobe, one clock wide, issued after the window closes. `wr_addr` and `wr_data` carry the address and data present when the window closed.
- R4: A window opened and closed by chip select, with write enable held low, writes the same way as a window opened and closed by write enable, with chip select held low.
- R5: While chip select and output enable are low and write enable is high, `data_oe` is high and `rdata` shows the selected read data.
- R6: When write enable falls during a read, `data_oe` drops and stays low while write enable is low.
- R7: While the synchronised supply-good flag is low, no write strobe is issued and `data_oe` stays low.
- R8: After supply-good rises, access is refused until it has been high for HOLD_MS milliseconds of a CLK_HZ clock. Access is granted once that time has passed.
- R9: If supply-good drops, even briefly, the hold-off starts again from zero.
- R10: A write window during which protection was engaged at any time produces no strobe, even if access is granted again before the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Bus chip select, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Bus write data |
| pwr_good | input | 1 | Supply within tolerance |
| reg_rdata | input | DATA_W | Read data from the register bank |
| mem_rdata | input | DATA_W | Read data from user memory |
| rdata | output | DATA_W | Data to place on the bus |
| data_oe | output | 1 | Enable for the bus data drivers |
| reg_we | output | 1 | Register-bank write strobe |
| mem_we | output | 1 | User-memory write strobe |
| wr_addr | output | ADDR_W | Address of the write strobe |
| wr_data | output | DATA_W | Data of the write strobe |

## Verification
The bench builds the block with ADDR_W of 5, CLK_HZ of 10000 and HOLD_MS of 200. This gives a hold-off of 2000 clocks. The narrow address makes it possible to sweep every address with both write styles and with reads, and the sweep crosses the boundary between the register range and the memory range. The short hold-off makes it practical to run the full lockout, a restart caused by a supply glitch, and a write that spans a protection event.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;
    typedef struct packed {
        logic cs;
        logic oe;
        logic we;
        logic pg;
    } bus_ctl_t;
endpackage

// File: rtl/pfwp_sync.sv
module pfwp_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;
    st_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/pfwp_guard.sv
module pfwp_guard #(
    parameter int HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_i,
    output logic ok_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ok;
    } st_t;
    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pg_i) begin
            st_d.cnt = '0;
            st_d.ok  = 1'b0;
        end else if (!st_q.ok) begin
            if (st_q.cnt == CW'(HOLD_CYC - 1)) begin
                st_d.ok = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ok_o = st_q.ok;

    // R7
    ok_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_i |=> !ok_o);

    // R8
    ok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> $past(pg_i));
endmodule

// File: rtl/pfwp_access.sv
module pfwp_access #(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pfwp_pkg::bus_ctl_t ctl_i,
    input  logic              ok_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] reg_rdata_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              data_oe_o,
    output logic              reg_we_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    typedef struct packed {
        logic              win;
        logic              abort;
        logic              reg_we;
        logic              mem_we;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              data_oe;
        logic [DATA_W-1:0] rdata;
    } st_t;
    st_t st_d, st_q;

    logic win_now, win_end, fire, is_reg, rd_now;

    always_comb begin
        win_now = ctl_i.cs & ctl_i.we;
        win_end = st_q.win & ~win_now;
        is_reg  = (32'(addr_i) < NUM_REGS);
        fire    = win_end & ~st_q.abort & ok_i;
        rd_now  = ctl_i.cs & ctl_i.oe & ~ctl_i.we & ok_i;

        st_d         = st_q;
        st_d.win     = win_now;
        if (win_now) begin
            st_d.abort = (st_q.win ? st_q.abort : 1'b0) | ~ok_i;
        end
        st_d.reg_we  = fire & is_reg;
        st_d.mem_we  = fire & ~is_reg;
        if (fire) begin
            st_d.wr_addr = addr_i;
            st_d.wr_data = wdata_i;
        end
        st_d.data_oe = rd_now;
        st_d.rdata   = rd_now ? (is_reg ? reg_rdata_i : mem_rdata_i) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o   = st_q.rdata;
    assign data_oe_o = st_q.data_oe;
    assign reg_we_o  = st_q.reg_we;
    assign mem_we_o  = st_q.mem_we;
    assign wr_addr_o = st_q.wr_addr;
    assign wr_data_o = st_q.wr_data;

    // R3
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_o | mem_we_o) |=> !(reg_we_o | mem_we_o));

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we_o, mem_we_o}));

    // R7
    no_wr_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_o | mem_we_o) |-> $past(ok_i));

    // R6
    oe_off_on_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.we |=> !data_oe_o);
endmodule

// File: rtl/pfwp_bus_if.sv
module pfwp_bus_if #(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 14,
    parameter int CLK_HZ   = 50_000_000,
    parameter int HOLD_MS  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pwr_good,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              data_oe,
    output logic              reg_we,
    output logic              mem_we,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS;
    localparam int CTL_W    = $bits(pfwp_pkg::bus_ctl_t);

    pfwp_pkg::bus_ctl_t ctl_raw, ctl_s;
    logic [CTL_W-1:0]   ctl_bits;
    logic               ok;

    assign ctl_raw = '{cs: ~ce_n, oe: ~oe_n, we: ~we_n, pg: pwr_good};

    pfwp_sync #(.W(CTL_W)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(ctl_raw),
        .sync_o (ctl_bits)
    );
    assign ctl_s = ctl_bits;

    pfwp_guard #(.HOLD_CYC(HOLD_CYC)) guard_i (
        .clk  (clk),
        .rst_n(rst_n),
        .pg_i (ctl_s.pg),
        .ok_o (ok)
    );

    pfwp_access #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS)
    ) access_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_i      (ctl_s),
        .ok_i       (ok),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .reg_rdata_i(reg_rdata),
        .mem_rdata_i(mem_rdata),
        .rdata_o    (rdata),
        .data_oe_o  (data_oe),
        .reg_we_o   (reg_we),
        .mem_we_o   (mem_we),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );
endmodule

// File: tb/pfwp_bus_if_tb.sv
module pfwp_bus_if_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 5;
    localparam int DW         = 8;
    localparam int NREG       = 14;
    localparam int HZ         = 10000;
    localparam int HMS        = 200;
    localparam int HOLD       = (HZ / 1000) * HMS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          pwr_good = 1'b1;
    logic [DW-1:0] reg_rdata, mem_rdata, rdata, wr_data;
    logic          data_oe, reg_we, mem_we;
    logic [AW-1:0] wr_addr;

    int checks = 0, errors = 0;
    int n_reg = 0, n_mem = 0;
    logic [AW-1:0] last_a;
    logic [DW-1:0] last_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign reg_rdata = DW'(addr) ^ 8'h5A;
    assign mem_rdata = DW'(addr) + 8'h31;

    pfwp_bus_if #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NREG),
                  .CLK_HZ(HZ), .HOLD_MS(HMS)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .pwr_good(pwr_good),
        .reg_rdata(reg_rdata), .mem_rdata(mem_rdata),
        .rdata(rdata), .data_oe(data_oe), .reg_we(reg_we), .mem_we(mem_we),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (reg_we) n_reg++;
        if (mem_we) n_mem++;
        if (reg_we | mem_we) begin
            last_a = wr_addr;
            last_d = wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // cs_style=1: chip select opens and closes the window, else write enable does
    task automatic bus_write(input int a, input int d, input bit cs_style);
        @(negedge clk);
        addr = AW'(a); wdata = DW'(d);
        if (cs_style) begin
            we_n = 0; ticks(3); ce_n = 0; ticks(4); ce_n = 1; ticks(3); we_n = 1;
        end else begin
            ce_n = 0; ticks(3); we_n = 0; ticks(4); we_n = 1; ticks(3); ce_n = 1;
        end
        ticks(6);
    endtask

    task automatic write_expect(input int a, input int d, input bit cs_style,
                                input bit allowed, input string req);
        int r0, m0, exp_r, exp_m;
        r0 = n_reg; m0 = n_mem;
        bus_write(a, d, cs_style);
        exp_r = (allowed && a < NREG) ? 1 : 0;
        exp_m = (allowed && a >= NREG) ? 1 : 0;
        chk(n_reg - r0 == exp_r, req, n_reg - r0, exp_r);
        chk(n_mem - m0 == exp_m, req, n_mem - m0, exp_m);
        if (allowed) begin
            chk(last_a == AW'(a), req, last_a, a);
            chk(last_d == DW'(d), req, last_d, d);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        ticks(3);
        // R1 reset state
        chk(data_oe == 0 && reg_we == 0 && mem_we == 0 && rdata == 0, "R1",
            {data_oe, reg_we, mem_we}, 0);
        rst_n = 1;
        // R8 inside hold-off after reset: write refused
        write_expect(3, 8'h11, 1'b1, 1'b0, "R8 early");
        ticks(HOLD - 200);
        write_expect(20, 8'h12, 1'b0, 1'b0, "R8 near end");
        ticks(200);
        write_expect(20, 8'h13, 1'b0, 1'b1, "R8 after");

        // R2 R3 R4 sweep with both write styles
        for (int a = 0; a < (1 << AW); a++) begin
            write_expect(a, (a * 7 + 3) & 8'hFF, 1'b1, 1'b1, "R2 R3 R4 cs-style");
            write_expect(a, (a * 13 + 90) & 8'hFF, 1'b0, 1'b1, "R2 R3 R4 we-style");
        end

        // R5 R6 read sweep
        for (int a = 0; a < (1 << AW); a++) begin
            int exp;
            @(negedge clk);
            addr = AW'(a);
            ce_n = 0; oe_n = 0; ticks(5);
            exp = (a < NREG) ? ((a ^ 8'h5A) & 8'hFF) : ((a + 8'h31) & 8'hFF);
            chk(data_oe == 1, "R5 oe", data_oe, 1);
            chk(rdata == DW'(exp), "R5 R2 rdata", rdata, exp);
            we_n = 0; ticks(4);
            chk(data_oe == 0, "R6", data_oe, 0);
            we_n = 1; ticks(1); ce_n = 1; oe_n = 1; ticks(4);
        end

        // R7 supply bad: no write, no read
        pwr_good = 0; ticks(5);
        write_expect(5, 8'h77, 1'b1, 1'b0, "R7 reg");
        write_expect(25, 8'h78, 1'b0, 1'b0, "R7 mem");
        @(negedge clk); addr = 2; ce_n = 0; oe_n = 0; ticks(5);
        chk(data_oe == 0, "R7 read", data_oe, 0);
        ce_n = 1; oe_n = 1;
        pwr_good = 1;
        ticks(HOLD + 20);
        write_expect(9, 8'h44, 1'b1, 1'b1, "R8 recovered");

        // R9 glitch restarts hold-off
        pwr_good = 0; ticks(5); pwr_good = 1;
        ticks(HOLD / 2);
        pwr_good = 0; ticks(2); pwr_good = 1;
        ticks(HOLD / 2 + 100);
        write_expect(16, 8'h55, 1'b0, 1'b0, "R9 restarted");
        ticks(HOLD / 2);
        write_expect(16, 8'h56, 1'b0, 1'b1, "R9 after");

        // R10 window spans a protection event
        begin
            int r0;
            r0 = n_reg;
            @(negedge clk); addr = 4; wdata = 8'hAB;
            ce_n = 0; we_n = 0; ticks(5);
            pwr_good = 0; ticks(3); pwr_good = 1;
            ticks(HOLD + 30);
            we_n = 1; ticks(2); ce_n = 1; ticks(6);
            chk(n_reg == r0, "R10", n_reg - r0, 0);
            write_expect(4, 8'hAC, 1'b0, 1'b1, "R10 next");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule